// File: doc/BRIEF.md
# Divided and Suspendable System Clock Gate

This block takes a free-running base clock and produces a system clock from it. The system clock runs at the base rate divided by a power of two, from 1 to 128. Each output pulse is exactly one high phase of the base clock. The base clock is passed through a gate whose enable is registered on the falling edge. The output is therefore low in every low phase of the base clock, and a high phase is never cut short.

Software controls the block through an 8-bit write port. Bits [2:0] select the divide exponent. Writing bit 5 as 1 suspends the block, which stops the system clock. Two kinds of event wake the block and restart the clock:
- a level on any of four port-match inputs;
- an enabled comparator whose output is low.

Restart happens whether or not the event is also used as an interrupt. The divide count is frozen during suspend and is not reset, so downstream logic continues from where it stopped. The suspend bit clears itself in hardware on wake-up, and both control fields can be read back.

Top module: `sysclk_divgate`

## Requirements
- R1: While running with exponent field value s (control bits [2:0]), consecutive output pulses are exactly 2^s base cycles apart. Each pulse covers exactly one base high phase.
- R2: After reset the exponent is 7 (ratio 128), the block is not suspended and ctrl_o reads 0x07. The first pulse occupies the first base high phase after reset release.
- R3: A write with bit 5 set suspends the block at the edge that takes the write. No output pulse follows, and suspended_o is 1 from that edge.
- R4: While suspended, a 1 on any one of the four port_match_i bits wakes the block.
- R5: While suspended, cmp_en_i=1 together with cmp_out_i=0 wakes the block. A low cmp_out_i with cmp_en_i=0 has no effect.
- R6: Wake inputs are level-sensitive and pass through one base-clock register. A wake level held for one base cycle clears suspended_o at the second rising edge after it was applied.
- R7: The divide count freezes while suspended and continues from the same value after wake-up. The pulse spacing across a suspend is therefore the ratio plus the number of suspended cycles.
- R8: ctrl_o has the pending exponent in bits [2:0] and the suspend state in bit 5, with all other bits 0. Bit 5 returns to 0 on wake-up without a software write.
- R9: A new exponent does not cut short the interval in progress. It sets the spacing only from the next output pulse on.
- R10: A wake level while not suspended has no effect. A write with bit 5 clear does not suspend.
- R11: sys_clk_o is 0 during every low phase of the base clock.
- R12: When a suspend write and a registered wake arrive at the same edge while suspended, the write wins and the block stays suspended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Free-running base clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Control write strobe |
| wr_data_i | input | 8 | Control write data: [2:0] exponent, [5] suspend |
| port_match_i | input | 4 | Port-match wake levels, one per port |
| cmp_en_i | input | 1 | Comparator enable |
| cmp_out_i | input | 1 | Comparator output (low wakes when enabled) |
| sys_clk_o | output | 1 | Gated, divided system clock |
| suspended_o | output | 1 | Block is suspended |
| ctrl_o | output | 8 | Control read-back |

## Verification
The assertions assume that the write port and the wake inputs change only between rising base edges, well clear of the falling edge that samples the gate enable. The bench drives every input two nanoseconds after a rising edge, so each change sits in the high phase and is captured by the following rising edge. The assertions also assume that reset is released away from a falling edge. The bench releases reset at the same point in the high phase, so the first falling edge after release sees settled state.

// File: rtl/sysclk_divgate_pkg.sv
package sysclk_divgate_pkg;
  parameter int unsigned SEL_W    = 3;
  parameter int unsigned CTRL_W   = 8;
  parameter int unsigned SUSP_POS = 5;
  parameter int unsigned N_MATCH  = 4;
endpackage

// File: rtl/sysclk_wake_sync.sv
module sysclk_wake_sync #(
  parameter int unsigned N_MATCH = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [N_MATCH-1:0] match_i,
  input  logic               cmp_en_i,
  input  logic               cmp_out_i,
  output logic               wake_o
);
  logic wake_raw;
  logic wake_q;

  assign wake_raw = (|match_i) | (cmp_en_i & ~cmp_out_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) wake_q <= 1'b0;
    else         wake_q <= wake_raw;
  end

  assign wake_o = wake_q;

  // R5
  cmp_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (match_i == '0 && !cmp_en_i) |=> !wake_q);
endmodule

// File: rtl/sysclk_susp_reg.sv
module sysclk_susp_reg (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic wake_i,
  output logic susp_o
);
  logic susp_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     susp_q <= 1'b0;
    else if (set_i)  susp_q <= 1'b1;   // write beats wake
    else if (wake_i) susp_q <= 1'b0;
  end

  assign susp_o = susp_q;

  // R12
  set_win_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> susp_q);
  // R6
  wake_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (susp_q && wake_i && !set_i) |=> !susp_q);
  // R10
  no_self_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!susp_q && !set_i) |=> !susp_q);
  // R4
  stay_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (susp_q && !wake_i) |=> susp_q);
endmodule

// File: rtl/sysclk_div_cnt.sv
module sysclk_div_cnt #(
  parameter  int unsigned SEL_W = 3,
  localparam int unsigned CNT_W = (1 << SEL_W) - 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             sel_we_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic [SEL_W-1:0] sel_o,
  output logic             tick_o
);
  logic [SEL_W-1:0] sel_q;
  logic [SEL_W-1:0] act_sel_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] reload;
  logic             at_edge;

  assign reload  = ~({CNT_W{1'b1}} << sel_q);
  assign at_edge = (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       sel_q <= '1;
    else if (sel_we_i) sel_q <= sel_i;
  end

  // pending exponent is adopted only at a period boundary
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q     <= '0;
      act_sel_q <= '1;
    end else if (run_i) begin
      if (at_edge) begin
        cnt_q     <= reload;
        act_sel_q <= sel_q;
      end else begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end

  assign sel_o  = sel_q;
  assign tick_o = run_i & at_edge;

  // R9
  sel_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q != '0) |=> $stable(act_sel_q));
  // R7
  frozen_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> $stable(cnt_q));
  // R1
  range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= ~({CNT_W{1'b1}} << act_sel_q));
endmodule

// File: rtl/sysclk_gate_cell.sv
module sysclk_gate_cell (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic en_o,
  output logic gclk_o
);
  logic en_q;

  // enable changes only while clk_i is low
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) en_q <= 1'b0;
    else         en_q <= en_i;
  end

  assign gclk_o = clk_i & en_q;
  assign en_o   = en_q;
endmodule

// File: rtl/sysclk_divgate.sv
module sysclk_divgate
  import sysclk_divgate_pkg::*;
#(
  parameter int unsigned P_SEL_W    = SEL_W,
  parameter int unsigned P_CTRL_W   = CTRL_W,
  parameter int unsigned P_SUSP_POS = SUSP_POS,
  parameter int unsigned P_N_MATCH  = N_MATCH
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  wr_en_i,
  input  logic [P_CTRL_W-1:0]   wr_data_i,
  input  logic [P_N_MATCH-1:0]  port_match_i,
  input  logic                  cmp_en_i,
  input  logic                  cmp_out_i,
  output logic                  sys_clk_o,
  output logic                  suspended_o,
  output logic [P_CTRL_W-1:0]   ctrl_o
);
  logic               wake_q;
  logic               susp_q;
  logic               susp_set;
  logic               tick;
  logic               gate_en;
  logic [P_SEL_W-1:0] sel_q;
  logic               unused_wr;

  assign susp_set  = wr_en_i & wr_data_i[P_SUSP_POS];
  assign unused_wr = ^wr_data_i;

  sysclk_wake_sync #(.N_MATCH(P_N_MATCH)) u_wake (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .match_i  (port_match_i),
    .cmp_en_i (cmp_en_i),
    .cmp_out_i(cmp_out_i),
    .wake_o   (wake_q)
  );

  sysclk_susp_reg u_susp (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .set_i (susp_set),
    .wake_i(wake_q),
    .susp_o(susp_q)
  );

  sysclk_div_cnt #(.SEL_W(P_SEL_W)) u_cnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .run_i   (~susp_q),
    .sel_we_i(wr_en_i),
    .sel_i   (wr_data_i[P_SEL_W-1:0]),
    .sel_o   (sel_q),
    .tick_o  (tick)
  );

  sysclk_gate_cell u_gate (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (tick),
    .en_o  (gate_en),
    .gclk_o(sys_clk_o)
  );

  always_comb begin
    ctrl_o                = '0;
    ctrl_o[P_SEL_W-1:0]   = sel_q;
    ctrl_o[P_SUSP_POS]    = susp_q;
  end

  assign suspended_o = susp_q;

  // R3
  gate_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    susp_q |-> !gate_en);
  // R3
  susp_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_data_i[P_SUSP_POS]) |=> suspended_o);
  // R8
  rd_susp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_o[P_SUSP_POS] == suspended_o);
endmodule

// File: tb/sysclk_divgate_test.sv
`timescale 1ns/100ps
module sysclk_divgate_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [3:0] pm = 4'h0;
  logic       cmp_en = 1'b0;
  logic       cmp_out = 1'b1;
  logic       sys_clk;
  logic       susp;
  logic [7:0] ctrl;

  int    errors = 0;
  int    checks = 0;
  string cur_req = "R2";
  bit    done = 1'b0;

  always #2.5 clk = ~clk;

  sysclk_divgate uut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_data_i(wr_data),
    .port_match_i(pm), .cmp_en_i(cmp_en), .cmp_out_i(cmp_out),
    .sys_clk_o(sys_clk), .suspended_o(susp), .ctrl_o(ctrl)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  // behavioural reference
  int m_cnt = 0, m_sel = 7, m_susp = 0, m_wake = 0, m_next = 1, exp_out = 0;
  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_sel = 7; m_susp = 0; m_wake = 0; m_next = 1; exp_out = 0;
    end else begin
      exp_out = m_next;
      if (m_susp == 0) begin
        if (m_cnt == 0) m_cnt = (1 << m_sel) - 1;
        else m_cnt = m_cnt - 1;
      end
      if (wr_en && wr_data[5]) m_susp = 1;
      else if (m_susp == 1 && m_wake == 1) m_susp = 0;
      if (wr_en) m_sel = int'(wr_data[2:0]);
      m_wake = ((pm != 0) || (cmp_en && !cmp_out)) ? 1 : 0;
      m_next = (m_susp == 0 && m_cnt == 0) ? 1 : 0;
    end
  end

  always @(posedge clk) begin
    #1;
    chk(int'(sys_clk) == exp_out, cur_req, "sys_clk high phase", int'(sys_clk), exp_out);
    chk(int'(susp) == m_susp, cur_req, "suspended_o", int'(susp), m_susp);
    chk(int'(ctrl) == (m_susp * 32 + m_sel), "R8", "ctrl_o", int'(ctrl), m_susp * 32 + m_sel);
  end

  always @(negedge clk) begin
    #0.5;
    chk(sys_clk == 1'b0, "R11", "sys_clk low phase", int'(sys_clk), 0);
  end

  task automatic cyc(input int n);
    repeat (n) begin @(posedge clk); #2; end
  endtask

  task automatic wr(input logic [7:0] d);
    wr_en = 1'b1; wr_data = d; cyc(1); wr_en = 1'b0;
  endtask

  initial begin
    cyc(3);
    chk(ctrl == 8'h07, "R2", "reset ctrl_o", int'(ctrl), 7);
    chk(susp == 1'b0, "R2", "reset suspended_o", int'(susp), 0);
    rst_n = 1'b1;
    cyc(300);
    cur_req = "R9"; wr(8'h00); cyc(140);
    cur_req = "R1"; wr(8'h02); cyc(20); wr(8'h01); cyc(12); wr(8'h03); cyc(30);
    cur_req = "R3"; wr(8'h23); cyc(6);
    chk(susp == 1'b1, "R3", "suspended after write", int'(susp), 1);
    chk(ctrl[5] == 1'b1, "R8", "suspend bit read", int'(ctrl[5]), 1);
    cur_req = "R5"; cmp_en = 1'b0; cmp_out = 1'b0; cyc(5);
    chk(susp == 1'b1, "R5", "disabled comparator ignored", int'(susp), 1);
    cmp_out = 1'b1;
    cur_req = "R6"; pm = 4'b0100; cyc(1); pm = 4'h0;
    chk(susp == 1'b1, "R6", "still suspended one edge after wake", int'(susp), 1);
    cyc(1);
    chk(susp == 1'b0, "R6", "woken two edges after wake", int'(susp), 0);
    chk(ctrl[5] == 1'b0, "R8", "suspend bit cleared", int'(ctrl[5]), 0);
    cur_req = "R7"; cyc(25);
    cur_req = "R5"; wr(8'h23); cyc(4); cmp_en = 1'b1; cmp_out = 1'b0; cyc(1);
    cmp_en = 1'b0; cmp_out = 1'b1; cyc(2);
    chk(susp == 1'b0, "R5", "enabled low comparator wakes", int'(susp), 0);
    cur_req = "R4";
    for (int i = 0; i < 4; i++) begin
      wr(8'h22); cyc(3);
      chk(susp == 1'b1, "R4", "suspended before port wake", int'(susp), 1);
      pm = 4'(1 << i); cyc(1); pm = 4'h0; cyc(2);
      chk(susp == 1'b0, "R4", "port wake", int'(susp), 0);
      cyc(7);
    end
    cur_req = "R10"; pm = 4'b1001; cyc(4); wr(8'h03); cyc(3); pm = 4'h0;
    chk(susp == 1'b0, "R10", "no suspend without bit 5", int'(susp), 0);
    cyc(10);
    cur_req = "R12"; wr(8'h21); cyc(3);
    pm = 4'b0001; cyc(1); pm = 4'h0; wr(8'h21); cyc(2);
    chk(susp == 1'b1, "R12", "write beats wake", int'(susp), 1);
    cmp_en = 1'b1; cmp_out = 1'b0; cyc(1); cmp_en = 1'b0; cmp_out = 1'b1; cyc(2);
    chk(susp == 1'b0, "R12", "later wake resumes", int'(susp), 0);
    cur_req = "R1"; wr(8'h07); cyc(300);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #750000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog all actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule